// File: doc/BRIEF.md
# RAS/CAS DRAM Controller

This block is a synchronous controller for a 256K x 8 asynchronous DRAM whose address pins are time-multiplexed. A host issues single-byte reads and writes over a valid/ready port with an 18-bit address. The controller turns each request into one strobe sequence on the memory pins. RAS falls with the row half of the address on the 9 pins. One cycle later the column half replaces it, and CAS falls after that. Read data is captured once both the row-access limit and the column-access limit have elapsed.

Three timing limits are each held by their own cycle counter: row access to data, column access to data, and the row cycle between successive RAS falls. A fourth counter holds the minimum spacing between column strobes. Reads use one of two output-enable orderings. By default the output enable goes low before CAS. A configuration input instead makes it go low one cycle after CAS.

A refresh scheduler walks a 9-bit row counter. Each refresh is a RAS-only dummy access, issued once per refresh interval. A due refresh takes priority over host traffic at the next access boundary. After reset the controller performs eight refresh accesses back to back before it accepts host requests.

Top module: `dram_ctrl`

## Requirements
- R1: After reset, RAS, CAS, WE and OE are all high, the data bus is released and `req_ready_o` is low. Ready stays low until exactly 8 RAS-only refresh accesses, to rows 0 to 7, have completed.
- R2: A host access drops RAS while the pins carry address bits 17:9 (the row). It drops CAS later, while the pins carry bits 8:0 (the column). CAS is low only while RAS is low.
- R3: For a read, `rsp_valid_o` is high for one cycle, T_RAC (6) cycles after the cycle in which RAS fell and at least T_CAC (2) cycles after CAS fell. `rsp_rdata_o` carries the byte stored at the requested address.
- R4: Successive RAS falls are at least T_RC (11) cycles apart. `req_ready_o` is low whenever RAS is low.
- R5: Successive CAS falls are at least T_PC (4) cycles apart.
- R6: With `late_read_i` = 0, OE goes low in an earlier cycle than CAS. With `late_read_i` = 1, OE goes low in a later cycle than CAS and is high when CAS falls.
- R7: For a write, WE is low and the data bus is driven with the request byte in the cycle before CAS falls. OE stays high throughout, and no response is produced.
- R8: Refresh accesses drop RAS without CAS and visit rows in increasing order modulo 512. After initialisation they start every 1560 cycles. A refresh start may slip by no more than one access (within +/-11 cycles of that spacing), because a due refresh wins over waiting host requests.
- R9: The data bus output enable is never high while OE is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, 100 MHz |
| rst_ni | input | 1 | Active-low asynchronous reset |
| late_read_i | input | 1 | 1 selects late OE ordering for reads |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Host request accepted when high with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Byte address, row in 17:9, column in 8:0 |
| req_wdata_i | input | 8 | Write byte |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | 8 | Read byte |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_addr_o | output | 9 | Multiplexed row/column address |
| dram_dq_o | output | 8 | Data bus, driven value |
| dram_dq_i | input | 8 | Data bus, sampled value |
| dram_dq_oe_o | output | 1 | Data bus driver enable |

## Verification
Back-to-back requests probe the row-cycle gap. A controller that reopened ready as soon as data returned would drop RAS again 7 cycles after the previous fall instead of 11. Reads in both OE orderings are checked at the CAS edge. Swapping the ordering, or letting OE fall in the same cycle as CAS, puts OE in the wrong state there. Read-after-write pairs at the address extremes and within one row catch swapped row and column halves and capture taken one cycle early. Each of these returns the wrong byte or a response at the wrong cycle. A long idle stretch together with dense traffic checks refresh rows and spacing, which a scheduler that lost to host requests or skipped a row would break.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [1:0] {OP_RD, OP_WR, OP_REF} op_e;
  typedef enum logic {ST_IDLE, ST_BUSY} st_e;
endpackage

// File: rtl/dram_gap_timer.sv
// Holds ok_o low until GAP cycles have passed since the last start_i.
module dram_gap_timer #(
  parameter int GAP = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ok_o
);
  localparam int W = $clog2(GAP + 1);
  localparam logic [W-1:0] GAP_V = W'(GAP);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= GAP_V;
    else if (start_i)       cnt_q <= W'(1);
    else if (cnt_q < GAP_V) cnt_q <= cnt_q + W'(1);
  end

  assign ok_o = (cnt_q >= GAP_V);

  // R4 / R5: a strobe start is only issued once the gap has expired
  p_gap_kept_r4_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ok_o) else $error("strobe started inside its gap");
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int INTERVAL  = 1560,
  parameter int ROW_W     = 9,
  parameter int INIT_REFS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_start_i,
  output logic             ref_req_o,
  output logic [ROW_W-1:0] ref_row_o,
  output logic             init_done_o
);
  localparam int TW = $clog2(INTERVAL);
  localparam int IW = $clog2(INIT_REFS + 1);
  localparam logic [TW-1:0] T_LAST = TW'(INTERVAL - 1);
  localparam logic [IW-1:0] I_LAST = IW'(INIT_REFS);

  logic [TW-1:0]    timer_q;
  logic [IW-1:0]    init_q;
  logic [ROW_W-1:0] row_q;
  logic             pend_q;
  logic             tick;

  assign tick = (timer_q == T_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_q <= '0;
      init_q  <= '0;
      row_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      timer_q <= tick ? '0 : timer_q + TW'(1);
      if (tick)             pend_q <= 1'b1;
      else if (ref_start_i) pend_q <= 1'b0;
      if (ref_start_i) begin
        row_q <= row_q + ROW_W'(1);
        if (init_q != I_LAST) init_q <= init_q + IW'(1);
      end
    end
  end

  assign init_done_o = (init_q == I_LAST);
  assign ref_req_o   = pend_q || !init_done_o;
  assign ref_row_o   = row_q;

  // R8: a refresh is only started while one is due
  p_ref_when_due_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_start_i |-> ref_req_o) else $error("refresh without request");
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 9,
  parameter int PIN_W  = 9,
  parameter int DATA_W = 8,
  parameter int T_RAC  = 6,
  parameter int T_CAC  = 2,
  parameter int T_PC   = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   late_read_i,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic                   req_write_i,
  input  logic [ROW_W+COL_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0]      req_wdata_i,
  output logic                   rsp_valid_o,
  output logic [DATA_W-1:0]      rsp_rdata_o,
  input  logic                   ref_req_i,
  input  logic [ROW_W-1:0]       ref_row_i,
  input  logic                   init_done_i,
  input  logic                   rc_ok_i,
  input  logic                   pc_ok_i,
  output logic                   ras_start_o,
  output logic                   cas_start_o,
  output logic                   ref_start_o,
  output logic                   ras_no,
  output logic                   cas_no,
  output logic                   we_no,
  output logic                   oe_no,
  output logic [PIN_W-1:0]       addr_o,
  output logic [DATA_W-1:0]      dq_o,
  input  logic [DATA_W-1:0]      dq_i,
  output logic                   dq_oe_o
);
  localparam int CAS_K = 2;  // column on pins one cycle before CAS
  localparam int K_MAX = T_RAC + T_CAC + T_PC + CAS_K;
  localparam int KW    = $clog2(K_MAX + 1);
  localparam int C_MAX = T_CAC + 1;
  localparam int CW    = $clog2(C_MAX + 1);

  st_e              st_q;
  op_e              op_q;
  logic [KW-1:0]    k_q;
  logic [CW-1:0]    c_q;
  logic             cas_done_q;
  logic             late_q;
  logic [COL_W-1:0] col_q;
  logic             idle, start_ref, start_host, cas_go, fin;

  always_comb begin
    idle        = (st_q == ST_IDLE);
    req_ready_o = idle && rc_ok_i && init_done_i && !ref_req_i;
    start_ref   = idle && rc_ok_i && ref_req_i;
    start_host  = req_valid_i && req_ready_o;
    cas_go      = !idle && (op_q != OP_REF) && !cas_done_q
                  && ((int'(k_q) + 1) >= CAS_K) && pc_ok_i;
    fin         = !idle && ((int'(k_q) + 1) >= T_RAC)
                  && ((op_q == OP_REF) || (cas_done_q && (int'(c_q) + 1) >= T_CAC));
  end

  assign ras_start_o = start_ref || start_host;
  assign ref_start_o = start_ref;
  assign cas_start_o = cas_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      op_q        <= OP_REF;
      k_q         <= '0;
      c_q         <= '0;
      cas_done_q  <= 1'b0;
      late_q      <= 1'b0;
      col_q       <= '0;
      ras_no      <= 1'b1;
      cas_no      <= 1'b1;
      we_no       <= 1'b1;
      oe_no       <= 1'b1;
      addr_o      <= '0;
      dq_o        <= '0;
      dq_oe_o     <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (idle) begin
        if (ras_start_o) begin
          st_q       <= ST_BUSY;
          k_q        <= '0;
          c_q        <= '0;
          cas_done_q <= 1'b0;
          late_q     <= late_read_i;
          ras_no     <= 1'b0;
          if (start_ref) begin
            op_q   <= OP_REF;
            addr_o <= PIN_W'(ref_row_i);
          end else begin
            op_q   <= req_write_i ? OP_WR : OP_RD;
            addr_o <= PIN_W'(req_addr_i[ROW_W+COL_W-1:COL_W]);
            col_q  <= req_addr_i[COL_W-1:0];
            dq_o   <= req_wdata_i;
          end
        end
      end else if (fin) begin
        st_q    <= ST_IDLE;
        ras_no  <= 1'b1;
        cas_no  <= 1'b1;
        we_no   <= 1'b1;
        oe_no   <= 1'b1;
        dq_oe_o <= 1'b0;
        if (op_q == OP_RD) begin
          rsp_valid_o <= 1'b1;
          rsp_rdata_o <= dq_i;
        end
      end else begin
        if (int'(k_q) < K_MAX) k_q <= k_q + KW'(1);
        if ((k_q == '0) && (op_q != OP_REF)) begin
          addr_o <= PIN_W'(col_q);
          if (op_q == OP_WR) begin
            we_no   <= 1'b0;
            dq_oe_o <= 1'b1;
          end else if (!late_q) begin
            oe_no <= 1'b0;
          end
        end
        if (cas_go) begin
          cas_no     <= 1'b0;
          cas_done_q <= 1'b1;
          c_q        <= '0;
        end else if (cas_done_q) begin
          if (int'(c_q) < C_MAX) c_q <= c_q + CW'(1);
          if (late_q && (op_q == OP_RD)) oe_no <= 1'b0;
        end
      end
    end
  end

  p_cas_in_ras_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_no |-> !ras_no) else $error("CAS low outside RAS");
  p_cas_after_ras_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) |-> !$past(ras_no)) else $error("CAS fell with RAS");
  p_no_oe_on_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> oe_no) else $error("OE low during write");
  p_bus_released_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> oe_no) else $error("bus driven with OE low");
  p_busy_not_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_no |-> !req_ready_o) else $error("ready during access");
  p_init_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_i |-> !req_ready_o) else $error("ready before init");
  p_rsp_after_ras_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(!ras_no)) else $error("response without access");
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
  parameter int ROW_W        = 9,
  parameter int COL_W        = 9,
  parameter int DATA_W       = 8,
  parameter int T_RAC        = 6,
  parameter int T_CAC        = 2,
  parameter int T_RC         = 11,
  parameter int T_PC         = 4,
  parameter int REF_INTERVAL = 1560,
  parameter int INIT_REFS    = 8,
  localparam int AW          = ROW_W + COL_W,
  localparam int PIN_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              late_read_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              dram_ras_no,
  output logic              dram_cas_no,
  output logic              dram_we_no,
  output logic              dram_oe_no,
  output logic [PIN_W-1:0]  dram_addr_o,
  output logic [DATA_W-1:0] dram_dq_o,
  input  logic [DATA_W-1:0] dram_dq_i,
  output logic              dram_dq_oe_o
);
  logic             ras_start, cas_start, ref_start;
  logic             rc_ok, pc_ok, ref_req, init_done;
  logic [ROW_W-1:0] ref_row;

  dram_gap_timer #(.GAP(T_RC)) u_rc_gap (
    .clk_i, .rst_ni, .start_i(ras_start), .ok_o(rc_ok)
  );

  dram_gap_timer #(.GAP(T_PC)) u_pc_gap (
    .clk_i, .rst_ni, .start_i(cas_start), .ok_o(pc_ok)
  );

  dram_refresh_sched #(
    .INTERVAL(REF_INTERVAL), .ROW_W(ROW_W), .INIT_REFS(INIT_REFS)
  ) u_ref (
    .clk_i, .rst_ni,
    .ref_start_i(ref_start),
    .ref_req_o  (ref_req),
    .ref_row_o  (ref_row),
    .init_done_o(init_done)
  );

  dram_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W), .DATA_W(DATA_W),
    .T_RAC(T_RAC), .T_CAC(T_CAC), .T_PC(T_PC)
  ) u_seq (
    .clk_i, .rst_ni, .late_read_i,
    .req_valid_i, .req_ready_o, .req_write_i, .req_addr_i, .req_wdata_i,
    .rsp_valid_o, .rsp_rdata_o,
    .ref_req_i  (ref_req),
    .ref_row_i  (ref_row),
    .init_done_i(init_done),
    .rc_ok_i    (rc_ok),
    .pc_ok_i    (pc_ok),
    .ras_start_o(ras_start),
    .cas_start_o(cas_start),
    .ref_start_o(ref_start),
    .ras_no     (dram_ras_no),
    .cas_no     (dram_cas_no),
    .we_no      (dram_we_no),
    .oe_no      (dram_oe_no),
    .addr_o     (dram_addr_o),
    .dq_o       (dram_dq_o),
    .dq_i       (dram_dq_i),
    .dq_oe_o    (dram_dq_oe_o)
  );
endmodule

// File: tb/dram_ctrl_bench.sv
module dram_ctrl_bench;
  localparam int T_RAC = 6, T_CAC = 2, T_RC = 11, T_PC = 4, REF_IV = 1560;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       late_read_i = 1'b0, req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [17:0] req_addr_i = '0;
  logic [7:0] req_wdata_i = '0, dq_i = 8'h5a;
  logic       req_ready_o, rsp_valid_o, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [7:0] rsp_rdata_o, dq_o;
  logic [8:0] addr_o;

  always #5 clk = ~clk;

  dram_ctrl u_dram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .late_read_i,
    .req_valid_i, .req_ready_o, .req_write_i, .req_addr_i, .req_wdata_i,
    .rsp_valid_o, .rsp_rdata_o,
    .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_we_no(we_n), .dram_oe_no(oe_n),
    .dram_addr_o(addr_o), .dram_dq_o(dq_o), .dram_dq_i(dq_i), .dram_dq_oe_o(dq_oe)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] dmem [int unsigned];  // memory model
  logic [7:0] rmem [int unsigned];  // expected contents

  function automatic logic [7:0] seed_byte(logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {6'd0, a[17:16]};
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // driver-side expectations
  logic [17:0] exp_addr = '0;
  logic [7:0]  exp_wdata = '0, exp_rdata = '0;
  bit          exp_rd_pend = 0;
  logic        lr_at_edge = 1'b0;
  always @(posedge clk) lr_at_edge <= late_read_i;

  // monitor state
  int cyc = 0, ras_cyc = -100, cas_cyc = -100, last_cas = -100, last_ref = -100000;
  int refs_seen = 0, ref_row_exp = 0;
  bit acc_cas = 0, acc_late = 0;
  logic [8:0] row_lat = '0;
  logic p_ras = 1, p_cas = 1, p_oe = 1, p_we = 1, p_dqoe = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (p_ras && !ras_n) begin
        chk(cyc - ras_cyc >= T_RC, "R4 ras gap", cyc - ras_cyc, T_RC);
        ras_cyc = cyc; row_lat = addr_o; acc_cas = 0; acc_late = lr_at_edge;
      end
      if (!ras_n) chk(!req_ready_o, "R4 ready in access", req_ready_o, 0);
      if (p_cas && !cas_n) begin
        acc_cas = 1;
        chk(!ras_n && cyc > ras_cyc, "R2 cas after ras", cyc - ras_cyc, 1);
        chk({row_lat, addr_o} == exp_addr, "R2 address", {row_lat, addr_o}, exp_addr);
        chk(cyc - last_cas >= T_PC, "R5 cas gap", cyc - last_cas, T_PC);
        last_cas = cyc; cas_cyc = cyc;
        if (!we_n) begin
          chk(!p_we && p_dqoe && oe_n && dq_o == exp_wdata, "R7 write setup", dq_o, exp_wdata);
          dmem[{row_lat, addr_o}] = dq_o;
        end else if (acc_late) begin
          chk(oe_n, "R6 late oe high at cas", oe_n, 1);
        end else begin
          chk(!p_oe, "R6 early oe before cas", p_oe, 0);
        end
      end
      if (p_oe && !oe_n && acc_late)
        chk(!p_cas, "R6 late oe after cas", p_cas, 0);
      if (!ras_n && !p_ras && !we_n) chk(oe_n, "R7 oe during write", oe_n, 1);
      if (dq_oe && !oe_n) chk(0, "R9 bus with oe", 1, 0);
      if (!p_ras && ras_n && !acc_cas) begin
        chk(row_lat == 9'(ref_row_exp), "R8 refresh row", row_lat, ref_row_exp & 511);
        ref_row_exp++; refs_seen++;
        if (refs_seen >= 10)
          chk(ras_cyc - last_ref >= REF_IV - T_RC && ras_cyc - last_ref <= REF_IV + T_RC,
              "R8 refresh spacing", ras_cyc - last_ref, REF_IV);
        last_ref = ras_cyc;
      end
      if (rsp_valid_o) begin
        chk(exp_rd_pend, "R3 response only for read", 0, 1);
        chk(cyc - ras_cyc == T_RAC && cyc - cas_cyc >= T_CAC, "R3 read latency",
            cyc - ras_cyc, T_RAC);
        chk(rsp_rdata_o == exp_rdata, "R3 read data", rsp_rdata_o, exp_rdata);
        exp_rd_pend = 0;
      end
      // memory model drives data while strobed for read
      if (!ras_n && !cas_n && !oe_n && we_n) begin
        if (dmem.exists({row_lat, addr_o})) dq_i = dmem[{row_lat, addr_o}];
        else dq_i = seed_byte({row_lat, addr_o});
      end else dq_i = 8'h5a;
      p_ras = ras_n; p_cas = cas_n; p_oe = oe_n; p_we = we_n; p_dqoe = dq_oe;
    end
  end

  task automatic do_req(input bit wr, input logic [17:0] a, input logic [7:0] d, input bit late);
    @(negedge clk);
    late_read_i = late; req_valid_i = 1; req_write_i = wr; req_addr_i = a; req_wdata_i = d;
    while (!req_ready_o) @(negedge clk);
    exp_addr = a; exp_wdata = d;
    if (wr) rmem[a] = d;
    else begin
      exp_rdata = rmem.exists(a) ? rmem[a] : seed_byte(a);
      exp_rd_pend = 1;
    end
    @(negedge clk);
    req_valid_i = 0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd4049);
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n && !dq_oe && !req_ready_o, "R1 reset state",
        {ras_n, cas_n, we_n, oe_n, dq_oe, req_ready_o}, 6'b111100);
    rst_n = 1;
    while (!req_ready_o) @(negedge clk);
    chk(refs_seen == 8, "R1 init refreshes", refs_seen, 8);
    // directed corners
    do_req(1, 18'h00000, 8'ha5, 0);
    do_req(1, 18'h3ffff, 8'h3c, 0);
    do_req(0, 18'h00000, 8'h00, 0);
    do_req(0, 18'h3ffff, 8'h00, 1);
    do_req(1, 18'h0a5ff, 8'h11, 1);
    do_req(1, 18'h0a400, 8'h22, 0);
    do_req(0, 18'h0a400, 8'h00, 1);
    do_req(0, 18'h0a5ff, 8'h00, 0);
    do_req(0, 18'h15a5a, 8'h00, 0);
    // random traffic
    for (int i = 0; i < 250; i++) begin
      logic [17:0] a;
      a = ($urandom % 2) ? {9'h0c3, 5'd0, 4'($urandom % 16)} : 18'($urandom);
      do_req(1'($urandom % 2), a, 8'($urandom), 1'($urandom % 2));
    end
    // idle: refresh alone
    repeat (3500) @(negedge clk);
    do_req(0, 18'h00000, 8'h00, 1);
    repeat (20) @(negedge clk);
    chk(refs_seen >= 11, "R8 refreshes issued", refs_seen, 11);
    chk(!exp_rd_pend, "R3 all reads answered", exp_rd_pend, 0);
    summary();
    $finish;
  end
endmodule